// File: doc/BRIEF.md
# AND-in-place register file

A small multi-port register file that works as an operate-in-place unit. It holds a parameterised number of words. Two address inputs select words that appear at once, without any clock, on two read outputs. A third address names the destination. While the operation enable is high, the bitwise AND of the two words being read is stored into the destination word at the next rising clock edge. No external write data exists: every stored value is either a reset value or the AND of two stored words.

The read outputs also act as the plain observation path. With the enable low, the two read addresses can scan the array freely and leave it unchanged. A synchronous, active-high reset loads every word. By default each word is cleared to zero. A preset option instead loads each word with a value computed from its index. That gives a chain of AND operations useful starting contents. A further option picks the structure of the read multiplexers.

Top module: `and_regfile`

## Requirements
- R1: While `op_en` is high and `rst` is low, at the next rising edge the word at `dst_addr` becomes the bitwise AND of the words at `lft_addr` and `rgt_addr` as they were before that edge.
- R2: `lft_data` shows the word at `lft_addr`, and `rgt_data` shows the word at `rgt_addr`, as a combinational function of the address and the contents. An address change is visible in the same cycle, with no clock edge in between.
- R3: The two read ports are independent. Two different words can be read in the same cycle, and equal addresses give equal data.
- R4: With `PRESET_EN` = 0 (the default), a rising edge with `rst` high sets every word to zero.
- R5: With `PRESET_EN` = 1, a rising edge with `rst` high sets word i to `PRESET_BASE` XOR (i × `PRESET_STEP`), truncated to `WORD_W` bits.
- R6: While `op_en` is low, no word changes.
- R7: An operation changes no word other than the one at `dst_addr`.
- R8: When `dst_addr` equals a read address, that read port shows the old value during the operation cycle. The new value appears only after the edge.
- R9: `rst` takes priority over `op_en`. An edge with both high leaves the reset contents, and the destination is not written.
- R10: When `lft_addr` equals `rgt_addr`, the operation copies that word unchanged into the destination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; loads the reset image |
| op_en | input | 1 | Operation enable; high writes the AND result at the edge |
| dst_addr | input | ADDR_W | Destination word address |
| lft_addr | input | ADDR_W | Left read address, also the first AND operand |
| rgt_addr | input | ADDR_W | Right read address, also the second AND operand |
| lft_data | output | WORD_W | Combinational contents of the word at `lft_addr` |
| rgt_data | output | WORD_W | Combinational contents of the word at `rgt_addr` |

## Verification
Two functions can fall in the same cycle: the combinational read of a word and the edge-triggered write into that same word. They meet when the destination matches a source address. The bench provokes this by naming the destination as the left operand, and elsewhere by making the next operation read the word the previous operation just wrote. The scoreboard expects the old value on the read port during the operation cycle and the ANDed value from the cycle after, and compares each expectation at the falling edge. A second overlap, reset and an operation enabled together, is judged by dumping the array afterwards and expecting the pure reset image.

// File: rtl/arf_pkg.sv
package arf_pkg;

   // Read multiplexer structure selected by the READ_ARCH parameter.
   typedef enum int {
      ARF_READ_INDEX = 0,   // indexed selection
      ARF_READ_ANDOR = 1    // one-hot decode followed by an AND-OR tree
   } arf_read_arch_e;

   localparam int ARF_MAX_W = 64;

   // Reset value of word idx when the preset option is on.
   function automatic logic [ARF_MAX_W-1:0] arf_preset_word(
      input int                   idx,
      input logic [ARF_MAX_W-1:0] base,
      input logic [ARF_MAX_W-1:0] step
   );
      logic [ARF_MAX_W-1:0] prod;
      prod = 64'(idx) * step;
      return base ^ prod;
   endfunction

endpackage

// File: rtl/arf_onehot_dec.sv
module arf_onehot_dec #(
   parameter int N  = 8,
   parameter int AW = 3
) (
   input  logic          en,
   input  logic [AW-1:0] sel,
   output logic [N-1:0]  hot
);

   if (N < 1) begin : g_bad_n
      $error("arf_onehot_dec: N must be at least 1");
   end
   if ((2 ** AW) < N) begin : g_bad_aw
      $error("arf_onehot_dec: AW too narrow for N");
   end

   for (genvar i = 0; i < N; i++) begin : g_line
      assign hot[i] = en && (sel == AW'(i));
   end

endmodule

// File: rtl/arf_word_array.sv
module arf_word_array
   import arf_pkg::*;
#(
   parameter int              N           = 8,
   parameter int              W           = 16,
   parameter int              PRESET_EN   = 0,
   parameter logic [63:0]     PRESET_BASE = 64'h0,
   parameter logic [63:0]     PRESET_STEP = 64'h0
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [N-1:0]        we_hot,
   input  logic [W-1:0]        wdata,
   output logic [N-1:0][W-1:0] words
);

   if (W < 1 || W > ARF_MAX_W) begin : g_bad_w
      $error("arf_word_array: W out of range");
   end

   for (genvar i = 0; i < N; i++) begin : g_word
      localparam logic [W-1:0] INIT_W = (PRESET_EN != 0) ?
         W'(arf_preset_word(i, PRESET_BASE, PRESET_STEP)) : {W{1'b0}};

      logic [W-1:0] word_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            word_q <= INIT_W;
         end else if (we_hot[i]) begin
            word_q <= wdata;
         end
      end

      assign words[i] = word_q;

      // Reset dominates any write request in the same cycle.
      AST_RESET_LOAD: assert property (@(posedge clk) rst |=> (word_q == INIT_W))
         else $error("word %0d not at reset image", i); // R9
   end

endmodule

// File: rtl/arf_read_port.sv
module arf_read_port
   import arf_pkg::*;
#(
   parameter int N         = 8,
   parameter int W         = 16,
   parameter int AW        = 3,
   parameter int READ_ARCH = 0
) (
   input  logic [N-1:0][W-1:0] words,
   input  logic [AW-1:0]       addr,
   output logic [W-1:0]        data
);

   if (READ_ARCH == int'(ARF_READ_ANDOR)) begin : g_andor
      logic [N-1:0] sel_hot;

      arf_onehot_dec #(.N(N), .AW(AW)) u_sel_dec (
         .en  (1'b1),
         .sel (addr),
         .hot (sel_hot)
      );

      always_comb begin
         data = '0;
         for (int i = 0; i < N; i++) begin
            data = data | (words[i] & {W{sel_hot[i]}});
         end
      end
   end else if (READ_ARCH == int'(ARF_READ_INDEX)) begin : g_index
      if ((2 ** AW) == N) begin : g_full
         assign data = words[addr];
      end else begin : g_partial
         always_comb begin
            data = '0;
            for (int i = 0; i < N; i++) begin
               if (addr == AW'(i)) data = words[i];
            end
         end
      end
   end else begin : g_bad_arch
      $error("arf_read_port: unknown READ_ARCH");
   end

endmodule

// File: rtl/and_regfile.sv
module and_regfile
   import arf_pkg::*;
#(
   parameter int          NUM_WORDS   = 8,
   parameter int          WORD_W      = 16,
   parameter int          ADDR_W      = $clog2(NUM_WORDS),
   parameter int          READ_ARCH   = 0,
   parameter int          PRESET_EN   = 0,
   parameter logic [63:0] PRESET_BASE = 64'h0,
   parameter logic [63:0] PRESET_STEP = 64'h0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              op_en,
   input  logic [ADDR_W-1:0] dst_addr,
   input  logic [ADDR_W-1:0] lft_addr,
   input  logic [ADDR_W-1:0] rgt_addr,
   output logic [WORD_W-1:0] lft_data,
   output logic [WORD_W-1:0] rgt_data
);

   localparam int NUM_PORTS = 2;

   if (NUM_WORDS < 2) begin : g_bad_depth
      $error("and_regfile: NUM_WORDS must be at least 2");
   end
   if (ADDR_W != $clog2(NUM_WORDS)) begin : g_bad_addr
      $error("and_regfile: ADDR_W must equal clog2(NUM_WORDS)");
   end
   if (PRESET_EN != 0 && PRESET_EN != 1) begin : g_bad_preset
      $error("and_regfile: PRESET_EN must be 0 or 1");
   end

   logic [NUM_WORDS-1:0][WORD_W-1:0] words;
   logic [NUM_WORDS-1:0]             we_hot;
   logic [WORD_W-1:0]                and_res;
   logic [ADDR_W-1:0]                rd_addr [NUM_PORTS];
   logic [WORD_W-1:0]                rd_data [NUM_PORTS];

   // Destination decode gated by the operation enable.
   arf_onehot_dec #(.N(NUM_WORDS), .AW(ADDR_W)) u_dst_dec (
      .en  (op_en),
      .sel (dst_addr),
      .hot (we_hot)
   );

   arf_word_array #(
      .N           (NUM_WORDS),
      .W           (WORD_W),
      .PRESET_EN   (PRESET_EN),
      .PRESET_BASE (PRESET_BASE),
      .PRESET_STEP (PRESET_STEP)
   ) u_array (
      .clk    (clk),
      .rst    (rst),
      .we_hot (we_hot),
      .wdata  (and_res),
      .words  (words)
   );

   assign rd_addr[0] = lft_addr;
   assign rd_addr[1] = rgt_addr;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rport
      arf_read_port #(
         .N         (NUM_WORDS),
         .W         (WORD_W),
         .AW        (ADDR_W),
         .READ_ARCH (READ_ARCH)
      ) u_rport (
         .words (words),
         .addr  (rd_addr[p]),
         .data  (rd_data[p])
      );
   end

   assign lft_data = rd_data[0];
   assign rgt_data = rd_data[1];

   // Write data: AND of the two words read in this cycle.
   assign and_res = rd_data[0] & rd_data[1];

   AST_AND_WRITTEN: assert property (@(posedge clk) disable iff (rst)
      (op_en && (32'(dst_addr) < NUM_WORDS)) |=>
      (words[$past(dst_addr)] == ($past(lft_data) & $past(rgt_data))))
      else $error("destination does not hold the AND result"); // R1

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !op_en |=> $stable(words))
      else $error("contents changed without an operation"); // R6

   AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (rst)
      (lft_addr == rgt_addr) |-> (lft_data == rgt_data))
      else $error("read ports disagree on the same address"); // R3

   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_keep
      AST_OTHERS_KEEP: assert property (@(posedge clk) disable iff (rst)
         (op_en && (dst_addr != ADDR_W'(i))) |=> $stable(words[i]))
         else $error("word %0d changed by a write elsewhere", i); // R7
   end

endmodule

// File: tb/and_regfile_bench.sv
`timescale 1ns/1ps
module and_regfile_bench;

   localparam int N  = 8;
   localparam int W  = 16;
   localparam int AW = 3;
   localparam logic [15:0] BASE = 16'hF7B3;
   localparam logic [15:0] STEP = 16'h1D29;

   typedef struct {
      int          port;   // 0 left, 1 right (preset unit); 2 left, 3 right (zero unit)
      logic [15:0] exp;
      string       tag;
   } item_t;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          op_en = 1'b0;
   logic [AW-1:0] dst_addr = '0;
   logic [AW-1:0] lft_addr = '0;
   logic [AW-1:0] rgt_addr = '0;
   logic [W-1:0]  lft_data, rgt_data, z_lft_data, z_rgt_data;

   int    checks = 0;
   int    failures = 0;
   bit    done = 1'b0;
   item_t sb_q[$];
   item_t it;
   logic [15:0] act;
   logic [15:0] model [N];

   always #2 clk = ~clk;   // 250 MHz

   and_regfile #(
      .NUM_WORDS (N), .WORD_W (W), .READ_ARCH (0), .PRESET_EN (1),
      .PRESET_BASE (64'(BASE)), .PRESET_STEP (64'(STEP))
   ) u_and_regfile (
      .clk (clk), .rst (rst), .op_en (op_en), .dst_addr (dst_addr),
      .lft_addr (lft_addr), .rgt_addr (rgt_addr),
      .lft_data (lft_data), .rgt_data (rgt_data)
   );

   and_regfile #(.READ_ARCH (1)) u_and_regfile_zero (
      .clk (clk), .rst (rst), .op_en (op_en), .dst_addr (dst_addr),
      .lft_addr (lft_addr), .rgt_addr (rgt_addr),
      .lft_data (z_lft_data), .rgt_data (z_rgt_data)
   );

   function automatic logic [15:0] preset_of(input int i);
      logic [15:0] prod;
      prod = 16'(i) * STEP;
      return BASE ^ prod;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < N; i++) model[i] = preset_of(i);
   endtask

   task automatic push(input int port, input logic [15:0] exp, input string tag);
      item_t x;
      x.port = port; x.exp = exp; x.tag = tag;
      sb_q.push_back(x);
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   // Scan the whole array through both ports, with the enable low.
   task automatic dump(input string tag);
      for (int k = 0; k < N / 2; k++) begin
         step();
         op_en = 1'b0;
         lft_addr = AW'(k);
         rgt_addr = AW'(k + N / 2);
         push(0, model[k], tag);
         push(1, model[k + N / 2], tag);
         push(2, 16'h0000, "R4 zero unit");
         push(3, 16'h0000, "R4 zero unit");
      end
   endtask

   // One operation cycle; the in-cycle reads are checked before the edge.
   task automatic do_op(input int d, input int l, input int r, input string tag);
      logic [15:0] nv;
      step();
      op_en = 1'b1;
      dst_addr = AW'(d);
      lft_addr = AW'(l);
      rgt_addr = AW'(r);
      push(0, model[l], tag);
      push(1, model[r], tag);
      nv = model[l] & model[r];
      model[d] = nv;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   // Monitor: drains the scoreboard at the falling edge.
   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         it = sb_q.pop_front();
         case (it.port)
            0:       act = lft_data;
            1:       act = rgt_data;
            2:       act = z_lft_data;
            default: act = z_rgt_data;
         endcase
         checks++;
         if (act !== it.exp) begin
            failures++;
            $display("FAIL %s port=%0d actual=%h expected=%h", it.tag, it.port, act, it.exp);
         end
      end
   end

   initial begin
      #(4 * 20000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog R1 actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      model_reset();
      rst = 1'b1;
      repeat (3) step();
      rst = 1'b0;

      // Reset images: preset unit (R5) and zero unit (R4).
      dump("R5 preset image");

      // R2: the address moves with no edge between drive and sample.
      step();
      op_en = 1'b0;
      lft_addr = 3'd6;
      rgt_addr = 3'd1;
      push(0, model[6], "R2 combinational read");
      push(1, model[1], "R2 combinational read");

      // R1, R3: distinct sources, result visible after the edge.
      do_op(2, 0, 5, "R3 distinct reads in op cycle");
      dump("R1 and result / R7 others kept");

      // R6: enable low with busy addresses.
      step();
      op_en = 1'b0;
      dst_addr = 3'd4;
      lft_addr = 3'd7;
      rgt_addr = 3'd2;
      push(0, model[7], "R6 idle read");
      step();
      dst_addr = 3'd0;
      dump("R6 no change while idle");

      // R8: destination equals the left source.
      do_op(3, 3, 6, "R8 old value during op");
      step();
      op_en = 1'b0;
      lft_addr = 3'd3;
      push(0, model[3], "R8 new value after edge");

      // R10: both sources equal, copy into destination.
      do_op(7, 1, 1, "R10 same source read");
      step();
      op_en = 1'b0;
      lft_addr = 3'd7;
      rgt_addr = 3'd1;
      push(0, model[7], "R10 copied word");
      push(1, model[1], "R10 source intact");

      // R1: back-to-back chain, second op reads the first result.
      do_op(4, 2, 3, "R1 chain first");
      do_op(0, 4, 7, "R1 chain second reads fresh word");
      dump("R1 chain result / R7");

      // R9: reset and enable together.
      step();
      rst = 1'b1;
      op_en = 1'b1;
      dst_addr = 3'd1;
      lft_addr = 3'd2;
      rgt_addr = 3'd3;
      model_reset();
      step();
      rst = 1'b0;
      op_en = 1'b0;
      dump("R9 reset wins over op");

      step();
      op_en = 1'b0;
      @(negedge clk);
      #1;
      done = 1'b1;
      summary();
      $finish;
   end

endmodule